// File: doc/BRIEF.md
# User-Mode Profiling Timer

This block is a countdown timer that hands control straight to a user-level sampling handler, with no trap into a privileged mode. Software arms it by writing a cycle budget, a handler entry address and a stack-skip amount through a small register port. A clock-enable input ticks the budget down by one. When the budget runs out, the block raises a redirect request toward instruction fetch. The request carries the handler address, the program counter that was interrupted, and a stack pointer lowered by the skip amount so the handler's frame clears the area below the stack that the ABI reserves.

The request stays up until fetch accepts it. While it is pending the budget does not move. Once the timer has fired the budget sits at zero, so each arming gives exactly one event. Writing zero leaves the timer disarmed. The interrupted program counter stays readable so the handler can attribute the sample.

Top module: `upt_top`

## Requirements
- R1: The register port selects by `reg_sel`. 0 is the budget, which keeps the low CNT_W bits of write data and reads back zero-extended. 1 is the handler address. 2 is the stack-skip amount. 3 is the resume address, which is read-only, and writes to it change nothing. `reg_rdata` always shows the selected register.
- R2: When the budget is nonzero and no request is pending, each cycle with `tick_en` high lowers the budget by one. A budget write in the same cycle takes priority, and that tick is dropped.
- R3: The timer fires only on a tick that takes the budget from 1 to 0. `rdr_valid` rises in the following cycle. A budget written as zero never fires.
- R4: After firing, the budget stays at zero until software writes it again, so one arming gives one request.
- R5: `rdr_target` equals the handler register value in the firing cycle.
- R6: `rdr_sp` equals `sp_in` minus the skip register, modulo 2^ADDR_W, both taken in the firing cycle.
- R7: `rdr_resume` equals `pc_in` in the firing cycle. The same value reads back at select 3 until the next firing.
- R8: `rdr_valid` holds, with `rdr_target`, `rdr_sp` and `rdr_resume` unchanged, until a cycle with `rdr_ready` high. It is low in the cycle after that handshake.
- R9: While `rdr_valid` is high, ticks do not change the budget. A budget write still loads, and counting resumes after the handshake.
- R10: Synchronous active-high reset clears all registers and drives `rdr_valid` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_en | input | 1 | Count enable, one budget step per high cycle |
| reg_wr | input | 1 | Register write strobe |
| reg_sel | input | 2 | Register select (see R1) |
| reg_wdata | input | ADDR_W | Register write data |
| reg_rdata | output | ADDR_W | Selected register read data |
| pc_in | input | ADDR_W | Current program counter |
| sp_in | input | ADDR_W | Current stack pointer |
| rdr_valid | output | 1 | Redirect request pending |
| rdr_ready | input | 1 | Fetch accepts the redirect |
| rdr_target | output | ADDR_W | Handler entry address |
| rdr_resume | output | ADDR_W | Interrupted program counter |
| rdr_sp | output | ADDR_W | Stack pointer for the handler |

## Verification
The budget runs down under several tick patterns: continuous ticks, ticks with gaps, and a budget of one that fires on the first tick. These separate an off-by-one expiry cycle from a correct one and show whether a gap cycle is wrongly counted. The handshake is driven with `rdr_ready` held high and with it held low for several cycles. This exposes a request that drops early, a payload that drifts, and counting that continues while the request is pending. Further cases cover a write that collides with the final tick, a budget written as zero, a write to the read-only register, and a skip larger than the stack pointer so that the subtraction wraps.

// File: rtl/upt_pkg.sv
package upt_pkg;
    localparam int ADDR_W = 32;
    localparam int CNT_W  = 16;

    typedef logic [ADDR_W-1:0] addr_t;

    typedef enum logic [1:0] {
        SEL_BUDGET  = 2'd0,
        SEL_HANDLER = 2'd1,
        SEL_SKIP    = 2'd2,
        SEL_RESUME  = 2'd3
    } upt_sel_e;

    typedef struct packed {
        addr_t target;
        addr_t resume;
        addr_t sp;
    } redirect_t;

    function automatic addr_t below_zone(addr_t sp, addr_t skip);
        return sp - skip;
    endfunction
endpackage

// File: rtl/upt_countdown.sv
module upt_countdown
    import upt_pkg::*;
#(
    parameter int W = CNT_W
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         tick,
    input  logic         hold,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic [W-1:0] count,
    output logic         fire
);
    localparam logic [W-1:0] ONE = W'(1);

    logic step;
    assign step = tick && !hold && !load && (count != '0);
    assign fire = step && (count == ONE);

    always_ff @(posedge clk) begin
        if (rst)       count <= '0;
        else if (load) count <= load_val;
        else if (step) count <= count - ONE;
    end

    // R2: one step down per accepted tick
    a_r2_step_down: assert property (@(posedge clk) disable iff (rst)
        (tick && !hold && !load && count != '0) |=> (count == $past(count) - ONE));
    // R4: an expired budget stays at zero without a write
    a_r4_stay_zero: assert property (@(posedge clk) disable iff (rst)
        (count == '0 && !load) |=> (count == '0));
    // R9: budget frozen while a request is pending
    a_r9_frozen: assert property (@(posedge clk) disable iff (rst)
        (hold && !load) |=> $stable(count));
endmodule

// File: rtl/upt_redirect.sv
module upt_redirect
    import upt_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      fire,
    input  addr_t     handler,
    input  addr_t     skip,
    input  addr_t     pc,
    input  addr_t     sp,
    input  logic      ready,
    output logic      valid,
    output redirect_t pkt
);
    always_ff @(posedge clk) begin
        if (rst) begin
            valid <= 1'b0;
            pkt   <= '0;
        end else if (fire) begin
            valid      <= 1'b1;
            pkt.target <= handler;
            pkt.resume <= pc;
            pkt.sp     <= below_zone(sp, skip);
        end else if (valid && ready) begin
            valid <= 1'b0;
        end
    end

    // R3: a new event never lands on a pending one
    a_r3_no_double: assert property (@(posedge clk) disable iff (rst)
        fire |-> !valid);
    // R8: request and payload hold until accepted
    a_r8_hold: assert property (@(posedge clk) disable iff (rst)
        (valid && !ready) |=> (valid && $stable(pkt)));
    // R8: request drops after the handshake
    a_r8_drop: assert property (@(posedge clk) disable iff (rst)
        (valid && ready) |=> !valid);
    // R6: stack pointer lowered by the skip amount
    a_r6_sp_skip: assert property (@(posedge clk) disable iff (rst)
        fire |=> (pkt.sp == $past(sp) - $past(skip)));
    // R7: resume address is the interrupted pc
    a_r7_resume: assert property (@(posedge clk) disable iff (rst)
        fire |=> (pkt.resume == $past(pc)));
endmodule

// File: rtl/upt_top.sv
module upt_top
    import upt_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              tick_en,
    input  logic              reg_wr,
    input  logic [1:0]        reg_sel,
    input  logic [ADDR_W-1:0] reg_wdata,
    output logic [ADDR_W-1:0] reg_rdata,
    input  logic [ADDR_W-1:0] pc_in,
    input  logic [ADDR_W-1:0] sp_in,
    output logic              rdr_valid,
    input  logic              rdr_ready,
    output logic [ADDR_W-1:0] rdr_target,
    output logic [ADDR_W-1:0] rdr_resume,
    output logic [ADDR_W-1:0] rdr_sp
);
    upt_sel_e   sel;
    addr_t      handler_q, skip_q;
    logic [CNT_W-1:0] budget;
    logic       fire, load_budget;
    redirect_t  pkt;

    assign sel         = upt_sel_e'(reg_sel);
    assign load_budget = reg_wr && (sel == SEL_BUDGET);

    always_ff @(posedge clk) begin
        if (rst) begin
            handler_q <= '0;
            skip_q    <= '0;
        end else if (reg_wr) begin
            if (sel == SEL_HANDLER) handler_q <= reg_wdata;
            if (sel == SEL_SKIP)    skip_q    <= reg_wdata;
        end
    end

    upt_countdown #(.W(CNT_W)) u_count (
        .clk      (clk),
        .rst      (rst),
        .tick     (tick_en),
        .hold     (rdr_valid),
        .load     (load_budget),
        .load_val (reg_wdata[CNT_W-1:0]),
        .count    (budget),
        .fire     (fire)
    );

    upt_redirect u_rdr (
        .clk     (clk),
        .rst     (rst),
        .fire    (fire),
        .handler (handler_q),
        .skip    (skip_q),
        .pc      (pc_in),
        .sp      (sp_in),
        .ready   (rdr_ready),
        .valid   (rdr_valid),
        .pkt     (pkt)
    );

    assign rdr_target = pkt.target;
    assign rdr_resume = pkt.resume;
    assign rdr_sp     = pkt.sp;

    always_comb begin
        unique case (sel)
            SEL_BUDGET:  reg_rdata = ADDR_W'(budget);
            SEL_HANDLER: reg_rdata = handler_q;
            SEL_SKIP:    reg_rdata = skip_q;
            default:     reg_rdata = pkt.resume;
        endcase
    end

    // R3: a request starts only from a budget of one
    a_r3_from_one: assert property (@(posedge clk) disable iff (rst)
        $rose(rdr_valid) |-> ($past(budget) == CNT_W'(1)));
    // R5: target is the handler register of the firing cycle
    a_r5_target: assert property (@(posedge clk) disable iff (rst)
        $rose(rdr_valid) |-> (rdr_target == $past(handler_q)));
    // R10: reset leaves no request pending
    a_r10_reset: assert property (@(posedge clk)
        $past(rst) |-> !rdr_valid);
endmodule

// File: tb/tb_upt_top.sv
`timescale 1ns/1ps
module tb_upt_top;
    localparam int AW = 32;
    localparam int CW = 16;

    logic clk = 1'b0;
    logic rst, tick_en, reg_wr, rdr_ready;
    logic [1:0] reg_sel;
    logic [AW-1:0] reg_wdata, pc_in, sp_in;
    logic [AW-1:0] reg_rdata, rdr_target, rdr_resume, rdr_sp;
    logic rdr_valid;

    int errors = 0;
    int checks = 0;
    bit run_cmp = 0;
    bit finished = 0;

    // reference state
    logic [AW-1:0] m_cnt, m_hdl, m_skip, m_res, m_tgt, m_sp;
    logic m_valid;

    always #4 clk = ~clk;

    upt_top dut (
        .clk(clk), .rst(rst), .tick_en(tick_en), .reg_wr(reg_wr),
        .reg_sel(reg_sel), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .pc_in(pc_in), .sp_in(sp_in), .rdr_valid(rdr_valid),
        .rdr_ready(rdr_ready), .rdr_target(rdr_target),
        .rdr_resume(rdr_resume), .rdr_sp(rdr_sp)
    );

    task automatic check(input bit ok, input string req,
                         input logic [AW-1:0] act, input logic [AW-1:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
        end
    endtask

    // behavioural model, advanced on each rising edge
    always @(posedge clk) begin
        logic fire, was_valid;
        if (rst) begin
            m_cnt = 0; m_hdl = 0; m_skip = 0; m_res = 0;
            m_tgt = 0; m_sp = 0; m_valid = 0;
        end else begin
            was_valid = m_valid;
            fire = tick_en && !was_valid && (m_cnt == 1)
                   && !(reg_wr && reg_sel == 2'd0);
            if (was_valid && rdr_ready) m_valid = 0;
            if (fire) begin
                m_valid = 1;
                m_tgt   = m_hdl;
                m_res   = pc_in;
                m_sp    = sp_in - m_skip;
            end
            if (reg_wr && reg_sel == 2'd0) m_cnt = reg_wdata & ((1 << CW) - 1);
            else if (tick_en && !was_valid && m_cnt != 0) m_cnt = m_cnt - 1;
            if (reg_wr && reg_sel == 2'd1) m_hdl  = reg_wdata;
            if (reg_wr && reg_sel == 2'd2) m_skip = reg_wdata;
        end
    end

    function automatic logic [AW-1:0] m_read(input logic [1:0] s);
        case (s)
            2'd0: return m_cnt;
            2'd1: return m_hdl;
            2'd2: return m_skip;
            default: return m_res;
        endcase
    endfunction

    // per-cycle comparison, away from the rising edge
    always @(negedge clk) if (run_cmp) begin
        check(rdr_valid === m_valid, "R3/R8 valid", AW'(rdr_valid), AW'(m_valid));
        if (m_valid) begin
            check(rdr_target === m_tgt, "R5 target", rdr_target, m_tgt);
            check(rdr_sp === m_sp, "R6 sp", rdr_sp, m_sp);
            check(rdr_resume === m_res, "R7 resume", rdr_resume, m_res);
        end
        check(reg_rdata === m_read(reg_sel), "R1/R2/R9 read", reg_rdata, m_read(reg_sel));
    end

    task automatic step(input bit tk, input bit wr, input logic [1:0] sel,
                        input logic [AW-1:0] d, input bit rdy);
        @(negedge clk);
        #1;
        tick_en = tk; reg_wr = wr; reg_sel = sel; reg_wdata = d;
        rdr_ready = rdy; pc_in = pc_in + 4;
    endtask

    task automatic wr_reg(input logic [1:0] sel, input logic [AW-1:0] d);
        step(0, 1, sel, d, 0);
    endtask

    task automatic idle(input int n, input bit tk, input logic [1:0] sel, input bit rdy);
        for (int i = 0; i < n; i++) step(tk, 0, sel, '0, rdy);
    endtask

    initial begin
        rst = 1; tick_en = 0; reg_wr = 0; reg_sel = 0; reg_wdata = 0;
        rdr_ready = 0; pc_in = 32'h0000_1000; sp_in = 32'h7fff_f000;
        repeat (3) @(posedge clk);
        @(negedge clk); #1 rst = 0;
        // R10: reset state
        check(rdr_valid === 1'b0, "R10 valid after reset", AW'(rdr_valid), 0);
        check(reg_rdata === '0, "R10 budget after reset", reg_rdata, 0);
        run_cmp = 1;

        // arm: handler, skip, budget 5, continuous ticks, slow ack
        wr_reg(2'd1, 32'h0040_2000);
        wr_reg(2'd2, 32'h0000_0080);
        wr_reg(2'd0, 32'd5);
        idle(5, 1, 2'd0, 0);
        step(1, 0, 2'd3, '0, 0);
        check(rdr_valid === 1'b1, "R3 fired after five ticks", AW'(rdr_valid), 1);
        check(rdr_sp === 32'h7fff_ef80, "R6 sp minus skip", rdr_sp, 32'h7fff_ef80);
        idle(4, 1, 2'd0, 0);  // R9: ticks ignored while pending
        check(reg_rdata === '0, "R4 budget stays zero", reg_rdata, 0);
        idle(1, 0, 2'd0, 1);
        idle(6, 1, 2'd0, 0);  // R4: no second event
        check(rdr_valid === 1'b0, "R4 one event per arming", AW'(rdr_valid), 0);

        // budget written as zero never fires
        wr_reg(2'd0, 32'd0);
        idle(8, 1, 2'd0, 1);
        check(rdr_valid === 1'b0, "R3 zero budget disarmed", AW'(rdr_valid), 0);

        // gapped ticks, ready held high
        wr_reg(2'd0, 32'd3);
        for (int i = 0; i < 10; i++) step(i[0], 0, 2'd0, '0, 1);

        // write colliding with the last tick wins
        wr_reg(2'd0, 32'd1);
        step(1, 1, 2'd0, 32'd4, 0);
        step(0, 0, 2'd0, '0, 0);
        check(reg_rdata === 32'd4, "R2 write beats tick", reg_rdata, 32'd4);
        check(rdr_valid === 1'b0, "R2 no fire on collision", AW'(rdr_valid), 0);
        idle(6, 1, 2'd0, 1);

        // budget of one, wrapping skip, write while pending
        wr_reg(2'd2, 32'h8000_0000);
        sp_in = 32'h0000_0100;
        wr_reg(2'd0, 32'h0001_0001);  // upper bits dropped (R1)
        step(1, 0, 2'd0, '0, 0);
        step(0, 1, 2'd0, 32'd2, 0);   // R9 load while pending
        check(rdr_sp === 32'h8000_0100, "R6 wrap", rdr_sp, 32'h8000_0100);
        idle(3, 1, 2'd0, 0);
        idle(1, 1, 2'd0, 1);
        idle(5, 1, 2'd3, 1);

        // resume register is read-only
        wr_reg(2'd3, 32'hdead_beef);
        step(0, 0, 2'd3, '0, 0);
        check(reg_rdata !== 32'hdead_beef, "R1 resume read-only", reg_rdata, m_res);
        idle(3, 0, 2'd1, 0);

        run_cmp = 0;
        finished = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #(8 * 200000);
        if (!finished) begin
            checks++; errors++;
            $display("FAIL watchdog expired");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule